// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit History

The block is a small, fully associative table that the instruction prefetch stage consults on every fetch. Each of its entries holds three things: the address of a conditional branch instruction, a two-bit saturating history counter, and the address the branch jumped to. The lookup is combinational. When the fetch address matches a valid entry whose counter leans toward taken, the block returns the stored target as the next fetch address. Otherwise it returns the sequential address, which is the fetch address plus the instruction size.

When a conditional branch resolves in the execute stage, the pipeline presents four values on the resolve port: the branch address, the real outcome, the computed target, and the next address that fetch actually followed. If the branch is already in the table, the block moves the entry's counter one step toward the outcome, and a taken outcome also refreshes the stored target. If the branch is not in the table, the block writes it into the slot named by a round-robin victim pointer. The block also compares the correct next address with the address that fetch followed. On a mismatch it raises a redirect one cycle later that carries the correct address. Flushing the wrong-path instructions is left to the surrounding pipeline.

The reset input is asserted asynchronously and is released inside the block through a two-stage synchronizer. For this reason the table comes out of reset two clock edges after the input rises.

Top module: `btb_predictor`

## Requirements
- R1: After reset no entry is valid, so every lookup reports lk_hit=0, lk_taken=0 and lk_next_pc = lk_pc + 4 (INST_BYTES = 4).
- R2: A valid lookup that matches no valid entry gives lk_hit=0 and lk_next_pc = lk_pc + 4.
- R3: A valid lookup that matches an entry gives lk_hit=1. If the entry's counter is 2 or 3, it gives lk_taken=1 and lk_next_pc = the stored target. If the counter is 0 or 1, it gives lk_taken=0 and lk_next_pc = lk_pc + 4.
- R4: Each resolve of a branch already in the table moves that entry's counter by one step. A taken outcome increments it and saturates at 3 (0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken). A not-taken outcome decrements it and saturates at 0. As a result, a branch in a strong state needs two consecutive opposite outcomes before its prediction flips.
- R5: A resolve of a branch not in the table allocates an entry that holds the branch address and rs_target. The new counter is 2 if the outcome was taken and 1 if it was not.
- R6: Allocation uses slots 0, 1, …, ENTRIES-1 in turn and then wraps to 0. With 8 entries, the ninth distinct branch evicts the first one allocated.
- R7: A taken resolve of a branch already in the table overwrites the stored target with rs_target.
- R8: In the cycle after a resolve, redir_valid is 1 exactly when the correct next address differs from rs_pred_next. The correct next address is rs_target if the branch was taken and rs_pc + 4 if it was not. When redir_valid is 1, redir_pc carries the correct next address.
- R9: A lookup in the same cycle as a resolve of the same address returns the table state from before that resolve.
- R10: When lk_valid is 0, lk_hit and lk_taken are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A prefetch lookup is presented |
| lk_pc | input | ADDR_W | Fetch address being looked up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_taken | output | 1 | Matched entry predicts taken |
| lk_next_pc | output | ADDR_W | Address selected for the next fetch |
| rs_valid | input | 1 | A conditional branch resolved this cycle |
| rs_pc | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome of the branch |
| rs_target | input | ADDR_W | Computed branch target |
| rs_pred_next | input | ADDR_W | Next address that fetch followed after the branch |
| redir_valid | output | 1 | Fetch must restart at redir_pc |
| redir_pc | output | ADDR_W | Correct next address after a misprediction |

## Verification
The bench walks one branch through every counter state. It checks that a single wrong outcome from a strong state leaves the prediction in place, that the counter saturates at both ends, and that a wrong initial counter on allocation changes the very first prediction. A design that flips on every outcome, or that wraps instead of saturating, predicts the wrong direction at those points.

It also fills all eight slots and then adds two more branches. It checks that the oldest two entries are evicted and the rest survive, which exposes a victim pointer that sticks or skips. A lookup in the same cycle as the first resolve must still miss. The redirect is checked for both directions and for a resolve whose followed path was correct, so a redirect that fires always, never, or with the wrong address is reported.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Two-bit saturating history, numeric order matters: bit 1 is the prediction.
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'd0,
    CTR_WEAK_NT   = 2'd1,
    CTR_WEAK_T    = 2'd2,
    CTR_STRONG_T  = 2'd3
  } hist_e;

  function automatic hist_e hist_step(input hist_e cur, input logic taken);
    hist_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) nxt = hist_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_STRONG_NT) nxt = hist_e'(cur - 2'd1);
    end
    return nxt;
  endfunction

  function automatic hist_e hist_init(input logic taken);
    return taken ? CTR_WEAK_T : CTR_WEAK_NT;
  endfunction

endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]             vld,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]              key,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic                           any_hit,
  output logic [IDX_W-1:0]               hit_idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tags[g] == key);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/btb_entry.sv
module btb_entry
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic              wr_taken,
  output logic              vld,
  output logic [ADDR_W-1:0] tag,
  output logic [ADDR_W-1:0] tgt,
  output hist_e             hist
);

  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] tag_q, tag_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  hist_e             hist_q, hist_d;
  logic              ce;

  assign ce = alloc_en | upd_en;

  always_comb begin
    vld_d  = vld_q;
    tag_d  = tag_q;
    tgt_d  = tgt_q;
    hist_d = hist_q;
    if (alloc_en) begin
      vld_d  = 1'b1;
      tag_d  = wr_pc;
      tgt_d  = wr_tgt;
      hist_d = hist_init(wr_taken);
    end else if (upd_en) begin
      hist_d = hist_step(hist_q, wr_taken);
      if (wr_taken) tgt_d = wr_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      tgt_q  <= '0;
      hist_q <= CTR_STRONG_NT;
    end else if (ce) begin
      vld_q  <= vld_d;
      tag_q  <= tag_d;
      tgt_q  <= tgt_d;
      hist_q <= hist_d;
    end
  end

  assign vld  = vld_q;
  assign tag  = tag_q;
  assign tgt  = tgt_q;
  assign hist = hist_q;

endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
    else                              ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/btb_redirect.sv
module btb_redirect #(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  input  logic [ADDR_W-1:0] rs_pred_next,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_pc
);

  logic [ADDR_W-1:0] fall_thru;
  logic [ADDR_W-1:0] correct_next;
  logic              mispred;
  logic              rv_q;
  logic [ADDR_W-1:0] rpc_q;

  assign fall_thru    = rs_pc + ADDR_W'(INST_BYTES);
  assign correct_next = rs_taken ? rs_target : fall_thru;
  assign mispred      = rs_valid && (correct_next != rs_pred_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= mispred;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rpc_q <= '0;
    else if (mispred) rpc_q <= correct_next;
  end

  assign redir_valid = rv_q;
  assign redir_pc    = rpc_q;

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 8,
  parameter int INST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_next_pc,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  input  logic [ADDR_W-1:0] rs_pred_next,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_pc
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Table state.
  logic [ENTRIES-1:0]             e_vld;
  logic [ENTRIES-1:0][ADDR_W-1:0] e_tag;
  logic [ENTRIES-1:0][ADDR_W-1:0] e_tgt;
  hist_e                          e_hist [ENTRIES];

  // Lookup side.
  logic [ENTRIES-1:0] lk_vec;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;
  logic [ADDR_W-1:0]  lk_sel_tgt;
  hist_e              lk_sel_hist;
  logic [ADDR_W-1:0]  lk_seq;

  btb_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_lk_match (
    .vld    (e_vld),
    .tags   (e_tag),
    .key    (lk_pc),
    .hit_vec(lk_vec),
    .any_hit(lk_any),
    .hit_idx(lk_idx)
  );

  always_comb begin
    lk_sel_tgt  = e_tgt[lk_idx];
    lk_sel_hist = e_hist[lk_idx];
  end

  assign lk_seq     = lk_pc + ADDR_W'(INST_BYTES);
  assign lk_hit     = lk_valid && lk_any;
  assign lk_taken   = lk_hit && lk_sel_hist[1];
  assign lk_next_pc = lk_taken ? lk_sel_tgt : lk_seq;

  // Resolve side.
  logic [ENTRIES-1:0] rs_vec;
  logic               rs_any;
  logic [IDX_W-1:0]   rs_idx;
  logic [IDX_W-1:0]   victim;
  logic               alloc;

  btb_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_rs_match (
    .vld    (e_vld),
    .tags   (e_tag),
    .key    (rs_pc),
    .hit_vec(rs_vec),
    .any_hit(rs_any),
    .hit_idx(rs_idx)
  );

  assign alloc = rs_valid && !rs_any;

  btb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk  (clk),
    .rst_n(rst_int_n),
    .adv  (alloc),
    .ptr  (victim)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic en_alloc;
    logic en_upd;
    assign en_alloc = alloc && (victim == IDX_W'(g));
    assign en_upd   = rs_valid && rs_vec[g];

    btb_entry #(.ADDR_W(ADDR_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .alloc_en(en_alloc),
      .upd_en  (en_upd),
      .wr_pc   (rs_pc),
      .wr_tgt  (rs_target),
      .wr_taken(rs_taken),
      .vld     (e_vld[g]),
      .tag     (e_tag[g]),
      .tgt     (e_tgt[g]),
      .hist    (e_hist[g])
    );
  end

  btb_redirect #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_redir (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .rs_valid    (rs_valid),
    .rs_pc       (rs_pc),
    .rs_taken    (rs_taken),
    .rs_target   (rs_target),
    .rs_pred_next(rs_pred_next),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc)
  );

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic [ADDR_W-1:0] lk_next_pc,
  input logic              rs_valid,
  input logic [ADDR_W-1:0] rs_pc,
  input logic              rs_taken,
  input logic [ADDR_W-1:0] rs_target,
  input logic [ADDR_W-1:0] rs_pred_next,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_pc
);

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |-> (lk_next_pc == lk_pc + ADDR_W'(INST_BYTES))); // R2

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_taken)); // R10

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> lk_hit); // R3

  AST_REDIR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(rs_valid)); // R8

  AST_REDIR_TAKEN_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && $past(rs_taken)) |-> (redir_pc == $past(rs_target))); // R8

  AST_REDIR_FALL_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !$past(rs_taken)) |->
      (redir_pc == $past(rs_pc) + ADDR_W'(INST_BYTES))); // R8

  AST_CORRECT_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && (rs_target == rs_pred_next)) |=> !redir_valid); // R8

endmodule

bind btb_predictor btb_predictor_chk #(
  .ADDR_W    (ADDR_W),
  .INST_BYTES(INST_BYTES)
) u_chk (.*);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lk_valid;
  logic [AW-1:0] lk_pc;
  logic          lk_hit;
  logic          lk_taken;
  logic [AW-1:0] lk_next_pc;
  logic          rs_valid;
  logic [AW-1:0] rs_pc;
  logic          rs_taken;
  logic [AW-1:0] rs_target;
  logic [AW-1:0] rs_pred_next;
  logic          redir_valid;
  logic [AW-1:0] redir_pc;

  always #5 clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .ENTRIES(8), .INST_BYTES(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_next_pc(lk_next_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_pred_next(rs_pred_next),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  typedef struct {
    logic          hit;
    logic          tk;
    logic [AW-1:0] nxt;
    logic          chk_nxt;
    string         req;
  } lk_exp_t;

  lk_exp_t       lq[$];
  int            ncmp = 0;
  int            nmis = 0;
  bit            done = 0;
  logic          rd_v_d = 1'b0, rd_v_q = 1'b0;
  logic [AW-1:0] rd_pc_d = '0, rd_pc_q = '0;
  string         rd_req_d = "", rd_req_q = "";

  always @(posedge clk) begin
    rd_v_q   <= rd_v_d;
    rd_pc_q  <= rd_pc_d;
    rd_req_q <= rd_req_d;
  end

  // Driver: one cycle of stimulus plus the expected results.
  task automatic step(input logic lv, input logic [AW-1:0] lpc, input logic chk,
                      input logic eh, input logic et, input logic [AW-1:0] en,
                      input string lreq,
                      input logic rv, input logic [AW-1:0] rpc, input logic rt,
                      input logic [AW-1:0] rtg, input logic [AW-1:0] rpn,
                      input string rreq);
    logic [AW-1:0] correct;
    @(negedge clk);
    #1;
    lk_valid = lv; lk_pc = lpc;
    rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_target = rtg; rs_pred_next = rpn;
    if (chk) lq.push_back('{eh, et, en, lv, lreq});
    correct  = rt ? rtg : rpc + 32'd4;
    rd_v_d   = rv && (correct != rpn);
    rd_pc_d  = correct;
    rd_req_d = rreq;
  endtask

  task automatic look(input logic [AW-1:0] pc, input logic eh, input logic et,
                      input logic [AW-1:0] en, input string req);
    step(1'b1, pc, 1'b1, eh, et, en, req, 1'b0, '0, 1'b0, '0, '0, "");
  endtask

  task automatic resolve(input logic [AW-1:0] pc, input logic tk,
                         input logic [AW-1:0] tg, input logic [AW-1:0] pn,
                         input string req);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "", 1'b1, pc, tk, tg, pn, req);
  endtask

  // Monitor: pops lookup expectations, compares redirects every cycle.
  initial begin
    lk_exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (lq.size() > 0) begin
        e = lq.pop_front();
        ncmp++;
        if (lk_hit !== e.hit || lk_taken !== e.tk ||
            (e.chk_nxt && lk_next_pc !== e.nxt)) begin
          nmis++;
          $display("FAIL %s lookup pc=%h: hit/taken/next = %b/%b/%h expected %b/%b/%h",
                   e.req, lk_pc, lk_hit, lk_taken, lk_next_pc, e.hit, e.tk, e.nxt);
        end
      end
      if (rd_v_q || redir_valid) begin
        ncmp++;
        if (redir_valid !== rd_v_q || (rd_v_q && redir_pc !== rd_pc_q)) begin
          nmis++;
          $display("FAIL R8 %s redirect valid/pc = %b/%h expected %b/%h",
                   rd_req_q, redir_valid, redir_pc, rd_v_q, rd_pc_q);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      ncmp++; nmis++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
      $finish;
    end
  end

  localparam logic [AW-1:0] A = 32'h100, B = 32'h200, D = 32'h700, E = 32'h710;

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; lk_pc = '0; rs_valid = 0; rs_pc = '0; rs_taken = 0;
    rs_target = '0; rs_pred_next = '0;
    #23 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    look(A, 0, 0, A + 4, "R1");
    // same-cycle lookup and first resolve of A: lookup sees the old table
    step(1'b1, A, 1'b1, 0, 0, A + 4, "R9",
         1'b1, A, 1'b1, 32'h800, A + 4, "taken-alloc");
    look(A, 1, 1, 32'h800, "R5");                 // allocated weak taken
    resolve(A, 0, 32'h800, 32'h800, "nt-mispred"); // 2 -> 1
    look(A, 1, 0, A + 4, "R4");
    resolve(A, 1, 32'h800, A + 4, "t-mispred");    // 1 -> 2
    resolve(A, 1, 32'h800, 32'h800, "correct");    // 2 -> 3, no redirect
    resolve(A, 0, 32'h800, 32'h800, "nt");         // 3 -> 2
    look(A, 1, 1, 32'h800, "R4");                  // one wrong outcome keeps taken
    resolve(A, 0, 32'h800, A + 4, "nt-correct");   // 2 -> 1
    look(A, 1, 0, A + 4, "R4");
    resolve(A, 0, 32'h800, A + 4, "nt");           // 1 -> 0
    resolve(A, 0, 32'h800, A + 4, "nt");           // stays 0
    resolve(A, 1, 32'h800, A + 4, "t");            // 0 -> 1
    look(A, 1, 0, A + 4, "R4");                    // saturation at 0
    resolve(A, 1, 32'h900, A + 4, "t-newtgt");     // 1 -> 2, target 0x900
    look(A, 1, 1, 32'h900, "R7");
    resolve(B, 0, 32'hA00, B + 4, "nt-alloc");     // slot 1, counter 1
    look(B, 1, 0, B + 4, "R5");
    look(32'h180, 0, 0, 32'h184, "R2");
    for (int i = 0; i < 6; i++)
      resolve(32'h300 + 16 * i, 1, 32'h4000 + 16 * i, 32'h4000 + 16 * i, "fill");
    look(A, 1, 1, 32'h900, "R6");                  // table full, A kept
    resolve(D, 1, 32'h5000, D + 4, "evict0");
    look(A, 0, 0, A + 4, "R6");                    // A evicted
    look(B, 1, 0, B + 4, "R6");
    look(D, 1, 1, 32'h5000, "R5");
    resolve(E, 0, 32'h6000, E + 4, "evict1");
    look(B, 0, 0, B + 4, "R6");
    look(32'h300, 1, 1, 32'h4000, "R6");
    look(32'h350, 1, 1, 32'h4050, "R3");
    step(1'b0, D, 1'b1, 0, 0, '0, "R10", 1'b0, '0, 1'b0, '0, '0, "");
    for (int i = 0; i < 3; i++)
      step(1'b0, '0, 1'b0, 0, 0, '0, "", 1'b0, '0, 1'b0, '0, '0, "");
    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
    $finish;
  end

endmodule